// File: doc/BRIEF.md
# Four-Port Pin Controller with Atomic Bit Updates

This block drives and samples 32 general-purpose pins arranged as four ports of eight bits each. Software reaches it over a simple 32-bit register bus. Through that bus it selects which pins the block owns, which of those drive, and the level each one drives. It can also read the pin levels after a two-flop synchronizer, and arm a per-pin interrupt that watches for a chosen polarity. All armed interrupts combine into a single interrupt line.

Every register also appears in an alias window 0x800 above its normal address. A write there carries a bit mask in bits [15:8] and new values in bits [7:0]. Only the masked bits change, so two agents can flip different pins of one port without a read-modify-write race. A set is done by putting the same byte in the mask and the value fields. A clear puts the mask in bits [15:8] and zero in bits [7:0].

The register bus is a control interface with plain strobes and no back-pressure. A write completes in the cycle it is presented. The read data register loads at the clock edge where a read is presented and holds its value until the next read.

Top module: `gpio_masked`

## Requirements
- R1: After reset, every register is zero: pad_out, pad_oe and irq are 0 and all readable registers read 0.
- R2: A write with bus_sel=1 and bus_wr=1 to offset G+4*P loads byte P of group G from bus_wdata[7:0]. The group offsets are 0x00 pin enable, 0x10 drive enable, 0x20 drive value, 0x30 input level, 0x40 interrupt status, 0x50 interrupt arm, 0x60 interrupt polarity and 0x70 interrupt clear. A read (bus_sel=1, bus_wr=0) puts that byte in bus_rdata[7:0], with the upper bits zero, at the next clock edge. bus_rdata holds its value when no read is presented.
- R3: A write to an address with bit 11 set changes only the bits selected by bus_wdata[15:8], setting them to the matching bits of bus_wdata[7:0]. All unselected bits keep their value.
- R4: Pin 8*P+B is driven from bit B of port P's drive value register: pad_out equals the drive value registers. pad_oe for a pin is 1 only when both its pin enable bit and its drive enable bit are 1.
- R5: The input level register returns pad_in delayed through two flops. A read presented in the same cycle as a pad change still returns the old level. A read presented two cycles later returns the new level.
- R6: A status bit is set on any clock edge where its pin enable bit is 1 and its synchronized input equals its polarity bit (1 means active high, 0 means active low). Once set, it stays set. Writing a 1 to the matching clear bit clears it, but if the set condition still holds in that cycle, the set wins. Through the alias window, a clear bit is applied only when it is both masked and 1.
- R7: irq is 1 exactly when some status bit and its arm bit are both 1.
- R8: Writes to the input level and status groups have no effect. Reads of the clear group return 0.
- R9: An access whose address has any of bits [10:7] or [1:0] nonzero is ignored for writes and reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address; bit 11 selects the masked alias |
| bus_wdata | input | 32 | Write data; [15:8] mask and [7:0] values in the alias |
| bus_rdata | output | 32 | Read data, loaded at the edge after a read |
| pad_in | input | 32 | Pin input levels, asynchronous |
| pad_out | output | 32 | Pin drive values |
| pad_oe | output | 32 | Pin drive enables |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check the following:
- the pins stay quiet after reset;
- masked alias writes never disturb unselected drive bits;
- pad_out, pad_oe and the interrupt line fall only as a result of a bus write;
- the read data register changes only after a read;
- reads of the clear group and of out-of-window addresses return zero.

Only the bench scenarios can show the following:
- the two-cycle synchronizer latency;
- the polarity choice and sticky status;
- set-over-clear priority;
- the alias-clear rule;
- the fact that writes to the input and status groups are lost.

The bench checks these both with fixed expected values and against a behavioural model on every clock.

// File: rtl/gpio_masked_pkg.sv
package gpio_masked_pkg;
  localparam int PORT_W = 8;
  localparam int SLOT_W = 2;
  localparam int GRP_W  = 3;

  typedef enum logic [GRP_W-1:0] {
    GRP_EN   = 3'd0,
    GRP_OE   = 3'd1,
    GRP_OUT  = 3'd2,
    GRP_IN   = 3'd3,
    GRP_STAT = 3'd4,
    GRP_IEN  = 3'd5,
    GRP_LVL  = 3'd6,
    GRP_CLR  = 3'd7
  } grp_e;

  function automatic logic [PORT_W-1:0] merge_bits(
    input logic [PORT_W-1:0] old_v,
    input logic [PORT_W-1:0] mask,
    input logic [PORT_W-1:0] val
  );
    return (old_v & ~mask) | (val & mask);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_masked_pkg::*;
#(
  parameter int AW    = 12,
  parameter int NPORT = 4
) (
  input  logic              [AW-1:0] addr,
  output logic                       acc_ok,
  output logic                       alias_sel,
  output grp_e                       grp,
  output logic          [SLOT_W-1:0] slot
);
  localparam int ALIAS_BIT = AW - 1;

  always_comb begin
    slot      = addr[3:2];
    grp       = grp_e'(addr[6:4]);
    alias_sel = addr[ALIAS_BIT];
    acc_ok    = (addr[ALIAS_BIT-1:7] == '0) && (addr[1:0] == 2'b00) &&
                (int'(slot) < NPORT);
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_masked_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  grp_e         grp,
  input  logic         alias_sel,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] wval,
  input  logic [W-1:0] sync_in,
  output logic [W-1:0] en_q,
  output logic [W-1:0] oe_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] lvl_q,
  output logic [W-1:0] ien_q,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] mask;
  logic [W-1:0] clr;
  logic [W-1:0] hit;

  always_comb begin
    mask = alias_sel ? wmask : '1;
    clr  = (wr && grp == GRP_CLR) ? (mask & wval) : '0;
    hit  = en_q & ~(sync_in ^ lvl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      oe_q   <= '0;
      out_q  <= '0;
      lvl_q  <= '0;
      ien_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wr) begin
        case (grp)
          GRP_EN:  en_q  <= merge_bits(en_q, mask, wval);
          GRP_OE:  oe_q  <= merge_bits(oe_q, mask, wval);
          GRP_OUT: out_q <= merge_bits(out_q, mask, wval);
          GRP_IEN: ien_q <= merge_bits(ien_q, mask, wval);
          GRP_LVL: lvl_q <= merge_bits(lvl_q, mask, wval);
          default: ;
        endcase
      end
      stat_q <= (stat_q & ~clr) | hit;
    end
  end
endmodule

// File: rtl/gpio_masked.sv
module gpio_masked
  import gpio_masked_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int NPORT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [AW-1:0]           bus_addr,
  input  logic [DW-1:0]           bus_wdata,
  output logic [DW-1:0]           bus_rdata,
  input  logic [NPORT*PORT_W-1:0] pad_in,
  output logic [NPORT*PORT_W-1:0] pad_out,
  output logic [NPORT*PORT_W-1:0] pad_oe,
  output logic                    irq
);
  localparam int NPIN = NPORT * PORT_W;

  logic              acc_ok;
  logic              alias_sel;
  grp_e              grp;
  logic [SLOT_W-1:0] slot;
  logic [NPIN-1:0]   sync_in;

  logic [PORT_W-1:0] en_a   [NPORT];
  logic [PORT_W-1:0] oe_a   [NPORT];
  logic [PORT_W-1:0] out_a  [NPORT];
  logic [PORT_W-1:0] lvl_a  [NPORT];
  logic [PORT_W-1:0] ien_a  [NPORT];
  logic [PORT_W-1:0] stat_a [NPORT];
  logic [NPORT-1:0]  port_irq;

  gpio_addr_dec #(.AW(AW), .NPORT(NPORT)) u_dec (
    .addr      (bus_addr),
    .acc_ok    (acc_ok),
    .alias_sel (alias_sel),
    .grp       (grp),
    .slot      (slot)
  );

  gpio_sync #(.W(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (sync_in)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic port_wr;
    assign port_wr = bus_sel && bus_wr && acc_ok && (int'(slot) == p);

    gpio_port #(.W(PORT_W)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (port_wr),
      .grp       (grp),
      .alias_sel (alias_sel),
      .wmask     (bus_wdata[2*PORT_W-1:PORT_W]),
      .wval      (bus_wdata[PORT_W-1:0]),
      .sync_in   (sync_in[p*PORT_W +: PORT_W]),
      .en_q      (en_a[p]),
      .oe_q      (oe_a[p]),
      .out_q     (out_a[p]),
      .lvl_q     (lvl_a[p]),
      .ien_q     (ien_a[p]),
      .stat_q    (stat_a[p])
    );

    assign pad_out[p*PORT_W +: PORT_W] = out_a[p];
    assign pad_oe[p*PORT_W +: PORT_W]  = en_a[p] & oe_a[p];
    assign port_irq[p]                 = |(stat_a[p] & ien_a[p]);
  end

  assign irq = |port_irq;

  logic [PORT_W-1:0] rd_byte;

  always_comb begin
    rd_byte = '0;
    if (acc_ok) begin
      case (grp)
        GRP_EN:   rd_byte = en_a[slot];
        GRP_OE:   rd_byte = oe_a[slot];
        GRP_OUT:  rd_byte = out_a[slot];
        GRP_IN:   rd_byte = sync_in[slot*PORT_W +: PORT_W];
        GRP_STAT: rd_byte = stat_a[slot];
        GRP_IEN:  rd_byte = ien_a[slot];
        GRP_LVL:  rd_byte = lvl_a[slot];
        default:  rd_byte = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      bus_rdata <= DW'(rd_byte);
    end
  end
endmodule

// File: rtl/gpio_masked_chk.sv
module gpio_masked_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [31:0] pad_out,
  input logic [31:0] pad_oe,
  input logic        irq
);
  logic [31:0] keep_m;
  logic        alias_out_wr;

  always_comb begin
    keep_m       = ~({24'b0, bus_wdata[15:8]} << {bus_addr[3:2], 3'b000});
    alias_out_wr = bus_sel && bus_wr && bus_addr[11] && (bus_addr[10:4] == 7'h02);
  end

  // R1: the pins are quiet right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pad_out == 0 && pad_oe == 0 && !irq));

  // R2: read data changes only after a read
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_rdata) |-> $past(bus_sel && !bus_wr));

  // R3: an alias write leaves unselected drive bits alone
  assert_alias_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alias_out_wr |=> (((pad_out ^ $past(pad_out)) & $past(keep_m)) == 0));

  // R4: pin outputs move only after a bus write
  assert_pads_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pad_out) || !$stable(pad_oe)) |-> $past(bus_sel && bus_wr));

  // R6: the interrupt can only drop after a write
  assert_irq_falls_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_sel && bus_wr));

  // R8: the clear group reads as zero
  assert_clr_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[6:4] == 3'd7) |=> (bus_rdata == 0));

  // R9: out-of-window reads return zero
  assert_bad_addr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr[10:7] != 0 || bus_addr[1:0] != 0)) |=> (bus_rdata == 0));
endmodule

bind gpio_masked gpio_masked_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .irq       (irq)
);

// File: tb/tb_gpio_masked.sv
`timescale 1ns/1ps
module tb_gpio_masked;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0;
  logic        bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_masked dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_en, m_oe, m_out, m_lvl, m_ien, m_stat, m_s1, m_s2, m_rd;
  logic [31:0] t_msk, t_val, t_clr, t_hit, t_src;
  int t_g, t_sh;
  bit t_ok;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_oe = 0; m_out = 0; m_lvl = 0; m_ien = 0;
      m_stat = 0; m_s1 = 0; m_s2 = 0; m_rd = 0;
    end else begin
      t_g   = int'(bus_addr[6:4]);
      t_sh  = int'(bus_addr[3:2]) * 8;
      t_ok  = (bus_addr[10:7] == 0) && (bus_addr[1:0] == 0);
      t_msk = {24'b0, (bus_addr[11] ? bus_wdata[15:8] : 8'hFF)} << t_sh;
      t_val = {24'b0, bus_wdata[7:0]} << t_sh;
      t_hit = m_en & ~(m_s2 ^ m_lvl);
      t_clr = 0;
      if (bus_sel && !bus_wr) begin
        case (t_g)
          0: t_src = m_en;  1: t_src = m_oe;  2: t_src = m_out; 3: t_src = m_s2;
          4: t_src = m_stat; 5: t_src = m_ien; 6: t_src = m_lvl; default: t_src = 0;
        endcase
        m_rd = t_ok ? ((t_src >> t_sh) & 32'hFF) : 0;
      end
      if (bus_sel && bus_wr && t_ok) begin
        case (t_g)
          0: m_en  = (m_en  & ~t_msk) | (t_val & t_msk);
          1: m_oe  = (m_oe  & ~t_msk) | (t_val & t_msk);
          2: m_out = (m_out & ~t_msk) | (t_val & t_msk);
          5: m_ien = (m_ien & ~t_msk) | (t_val & t_msk);
          6: m_lvl = (m_lvl & ~t_msk) | (t_val & t_msk);
          7: t_clr = t_msk & t_val;
          default: ;
        endcase
      end
      m_stat = (m_stat & ~t_clr) | t_hit;
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R4 model pad_out", pad_out, m_out);
      check("R4 model pad_oe", pad_oe, m_en & m_oe);
      check("R7 model irq", {31'b0, irq}, {31'b0, |(m_stat & m_ien)});
      check("R2 model rdata", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic report();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 pad_out", pad_out, 0);
    check("R1 pad_oe", pad_oe, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rd(12'h000, v); check("R1 enable reads zero", v, 0);
    // R2, R4
    wr(12'h004, 32'hF0);
    wr(12'h014, 32'h3C);
    rd(12'h004, v); check("R2 enable port1", v, 32'hF0);
    rd(12'h014, v); check("R2 drive enable port1", v, 32'h3C);
    check("R4 pad_oe gating", pad_oe, 32'h0000_3000);
    // R3
    wr(12'h028, 32'hA5);
    wr(12'h828, 32'h0F0F);
    rd(12'h028, v); check("R3 alias set", v, 32'hAF);
    check("R4 pad_out port2", pad_out, 32'h00AF_0000);
    wr(12'h828, 32'hA000);
    rd(12'h028, v); check("R3 alias clear", v, 32'h0F);
    // R5
    pad_in = 32'h1234_5678;
    rd(12'h03C, v); check("R5 old level", v, 0);
    @(negedge clk);
    rd(12'h03C, v); check("R5 new level", v, 32'h12);
    // R6, R7
    wr(12'h000, 32'h01);
    wr(12'h050, 32'h01);
    check("R7 irq armed", {31'b0, irq}, 1);
    rd(12'h040, v); check("R6 status low-active", v, 32'h01);
    wr(12'h070, 32'h01);
    rd(12'h040, v); check("R6 set wins over clear", v, 32'h01);
    wr(12'h060, 32'h01);
    wr(12'h070, 32'h01);
    check("R7 irq cleared", {31'b0, irq}, 0);
    pad_in = 32'h1234_5679;
    repeat (3) @(negedge clk);
    check("R6 high-active set", {31'b0, irq}, 1);
    pad_in = 32'h1234_5678;
    repeat (4) @(negedge clk);
    check("R6 sticky", {31'b0, irq}, 1);
    wr(12'h870, 32'h0100);
    check("R6 alias clear needs value", {31'b0, irq}, 1);
    wr(12'h870, 32'h0101);
    check("R6 alias clear", {31'b0, irq}, 0);
    // R8
    wr(12'h03C, 32'hFF);
    rd(12'h03C, v); check("R8 input write ignored", v, 32'h12);
    wr(12'h040, 32'hFF);
    rd(12'h040, v); check("R8 status write ignored", v, 0);
    rd(12'h044, v); check("R6 port1 sticky status", v, 32'hF0);
    rd(12'h070, v); check("R8 clear reads zero", v, 0);
    // R9
    wr(12'h100, 32'hFF);
    rd(12'h000, v); check("R9 bad addr write", v, 32'h01);
    rd(12'h100, v); check("R9 bad addr read", v, 0);
    wr(12'h022, 32'hFF);
    check("R9 misaligned write", pad_out, 32'h000F_0000);
    repeat (2) @(negedge clk);
    report();
  end
endmodule